// File: doc/BRIEF.md
# Four-Plane Frame Buffer Write/Read Datapath

This block sits between a host byte port and four 8-bit memory planes that together store one byte lane of a planar frame buffer. A host write at one address stores up to four plane bytes at once. How each plane byte is formed depends on one of four write modes. The modes differ in whether the byte comes from rotated host data, from a single set/reset bit spread over all eight bits, from one host data bit spread over the byte, or from a copy of the latched data. A 2-bit logic function can then combine that byte with the latch, and a bit mask chooses which pixel bits take the new value. A 4-bit plane mask input enables the write for each plane on its own.

A host read captures the byte of all four planes at that address into four latches. The block then returns one of two results. It can return the latch byte of the plane chosen by a read map select. It can also return a color-compare byte, in which bit i is 1 when the 4-bit colour formed by pixel i across the included planes matches a reference colour. Setup registers are written through an index/data pair: a 4-bit index written first, then the data byte for the register that index points to. The planes are modelled as plain synchronous arrays with a depth set by a parameter.

Top module: `planar_rw_path`

## Requirements
- R1: A configuration write with `cfg_sel`=0 loads the index from `cfg_wdata[3:0]`. A write with `cfg_sel`=1 stores `cfg_wdata` into the register that the index selects. The indexes are: 0 set/reset [3:0], 1 enable set/reset [3:0], 2 compare colour [3:0], 3 rotate count [2:0] and function [4:3], 4 read plane select [1:0], 5 write mode [1:0] and read mode [3], 7 compare include mask [3:0], 8 bit mask [7:0]. After reset every register is 0, except the bit mask, which is FF, and the include mask, which is F.
- R2: In write mode 0, plane p takes the host byte rotated right by the rotate count. When enable set/reset bit p is 1, plane p takes set/reset bit p copied into all 8 bits instead.
- R3: In write mode 1, every plane receives its own latch byte unchanged. The function and the bit mask have no effect.
- R4: In write mode 2, plane p takes host data bit p copied into all 8 bits.
- R5: In write mode 3, plane p takes set/reset bit p copied into all 8 bits, whatever enable set/reset holds. The mask used is the rotated host byte ANDed with the bit mask.
- R6: In modes 0, 2 and 3, the function combines the source byte with the plane's latch byte: 00 passes the source, 01 ANDs, 10 ORs and 11 XORs. The function is applied before the mask.
- R7: In modes 0, 2 and 3, each pixel bit whose mask bit is 1 takes the combined value. Each pixel bit whose mask bit is 0 keeps the latch bit.
- R8: A host read loads all four latches from the addressed planes at that clock edge and raises `host_rvalid` for exactly the following cycle. The latches change on no other event, and reset clears them.
- R9: When read mode is 0, `host_rdata` is the latch byte of the plane chosen by the read plane select.
- R10: When read mode is 1, bit i of `host_rdata` is 1 exactly when, for every plane p whose include bit is 1, latch bit i of plane p equals compare bit p. With no plane included the result is FF.
- R11: A host write changes plane p only when `plane_mask[p]` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 selects the index register, 1 selects the data register |
| cfg_wdata | input | 8 | Configuration write data |
| host_we | input | 1 | Host write strobe |
| host_re | input | 1 | Host read strobe |
| host_addr | input | AW | Plane address |
| host_wdata | input | 8 | Host write byte |
| plane_mask | input | 4 | Per-plane write enable |
| host_rdata | output | 8 | Read result, formed from the latches |
| host_rvalid | output | 1 | High in the cycle after a read |

## Verification
On every cycle the assertions check that the read-valid pulse follows each read by one cycle and never appears otherwise. They also check that the latches hold between reads, that no write changes a pixel bit the bit mask excludes, and that a compare read with every plane excluded returns all ones. What each write mode and function produces, the rotation amounts, the set/reset substitution and the per-plane gating can only be shown by the bench. It sweeps every mode and function against a byte-level model of the planes and reads each plane back afterwards.

// File: rtl/planar_rw_path.sv
module planar_rw_path #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic          cfg_sel,
  input  logic [7:0]    cfg_wdata,
  input  logic          host_we,
  input  logic          host_re,
  input  logic [AW-1:0] host_addr,
  input  logic [7:0]    host_wdata,
  input  logic [3:0]    plane_mask,
  output logic [7:0]    host_rdata,
  output logic          host_rvalid
);
  localparam int DEPTH = 1 << AW;
  localparam int NPL   = 4;

  logic [3:0] idx_q, sr_q, esr_q, cc_q, inc_q;
  logic [2:0] rcnt_q;
  logic [1:0] func_q, rsel_q, wmode_q;
  logic       rmode_q;
  logic [7:0] bm_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q <= '0; sr_q <= '0; esr_q <= '0; cc_q <= '0; inc_q <= 4'hF;
      rcnt_q <= '0; func_q <= '0; rsel_q <= '0; wmode_q <= '0;
      rmode_q <= 1'b0; bm_q <= 8'hFF;
    end else if (cfg_we) begin
      if (!cfg_sel) idx_q <= cfg_wdata[3:0];
      else begin
        case (idx_q)
          4'd0: sr_q  <= cfg_wdata[3:0];
          4'd1: esr_q <= cfg_wdata[3:0];
          4'd2: cc_q  <= cfg_wdata[3:0];
          4'd3: begin rcnt_q <= cfg_wdata[2:0]; func_q <= cfg_wdata[4:3]; end
          4'd4: rsel_q <= cfg_wdata[1:0];
          4'd5: begin wmode_q <= cfg_wdata[1:0]; rmode_q <= cfg_wdata[3]; end
          4'd7: inc_q <= cfg_wdata[3:0];
          4'd8: bm_q  <= cfg_wdata;
          default: ;
        endcase
      end
    end
  end

  wire [15:0] dbl = {host_wdata, host_wdata} >> rcnt_q;
  wire [7:0]  rot = dbl[7:0];
  wire [7:0]  msk = (wmode_q == 2'd3) ? (rot & bm_q) : bm_q;

  logic [NPL-1:0][7:0] lat_w;
  logic [NPL-1:0][7:0] wr_w;

  for (genvar p = 0; p < NPL; p++) begin : g_pl
    logic [7:0] arr [DEPTH];
    logic [7:0] lat_r;
    logic [7:0] src, alu;

    assign src = (wmode_q == 2'd2) ? {8{host_wdata[p]}} :
                 ((wmode_q == 2'd3) || esr_q[p]) ? {8{sr_q[p]}} : rot;

    always_comb begin
      case (func_q)
        2'd1:    alu = src & lat_r;
        2'd2:    alu = src | lat_r;
        2'd3:    alu = src ^ lat_r;
        default: alu = src;
      endcase
    end

    assign wr_w[p]  = (wmode_q == 2'd1) ? lat_r : ((alu & msk) | (lat_r & ~msk));
    assign lat_w[p] = lat_r;

    always_ff @(posedge clk) begin
      if (host_we && plane_mask[p]) arr[host_addr] <= wr_w[p];
    end

    always_ff @(posedge clk) begin
      if (!rst_n)       lat_r <= '0;
      else if (host_re) lat_r <= arr[host_addr];
    end

    p_bitmask_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
      host_we |-> (((wr_w[p] ^ lat_r) & ~bm_q) == 8'h00));
  end

  logic [7:0] cmp;
  for (genvar i = 0; i < 8; i++) begin : g_cmp
    wire [3:0] col = {lat_w[3][i], lat_w[2][i], lat_w[1][i], lat_w[0][i]};
    assign cmp[i] = &(~inc_q | ~(col ^ cc_q));
  end

  assign host_rdata = rmode_q ? cmp : lat_w[rsel_q];

  always_ff @(posedge clk) begin
    if (!rst_n) host_rvalid <= 1'b0;
    else        host_rvalid <= host_re;
  end

  p_rvalid_after_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    host_re |=> host_rvalid);
  p_rvalid_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !host_re |=> !host_rvalid);
  p_latch_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !host_re |=> $stable(lat_w));
  p_cmp_none_included_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rmode_q && inc_q == 4'h0) |-> host_rdata == 8'hFF);
endmodule

// File: tb/planar_rw_path_bench.sv
`timescale 1ns/1ps
module planar_rw_path_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 0, cfg_sel = 0;
  logic [7:0] cfg_wdata = 0;
  logic host_we = 0, host_re = 0;
  logic [7:0] host_addr = 0, host_wdata = 0;
  logic [3:0] plane_mask = 0;
  logic [7:0] host_rdata;
  logic host_rvalid;

  planar_rw_path #(.AW(8)) u_planar_rw_path (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .host_we(host_we), .host_re(host_re), .host_addr(host_addr), .host_wdata(host_wdata),
    .plane_mask(plane_mask), .host_rdata(host_rdata), .host_rvalid(host_rvalid));

  always #5 clk = ~clk;

  int n_run = 0, n_fail = 0;
  bit done = 0;
  int cyc = 0;

  logic [7:0] mm [4][16];
  logic [7:0] mlat [4];
  logic [3:0] m_sr = 0, m_esr = 0, m_cc = 0, m_inc = 4'hF;
  logic [2:0] m_cnt = 0;
  logic [1:0] m_fn = 0, m_rsel = 0, m_wm = 0;
  logic       m_rm = 0;
  logic [7:0] m_bm = 8'hFF;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual %0d expected below 150000", cyc);
      finish_run();
    end
  end

  task automatic cfg(input logic [3:0] i, input logic [7:0] v);
    @(negedge clk); cfg_we = 1; cfg_sel = 0; cfg_wdata = {4'h0, i};
    @(negedge clk); cfg_sel = 1; cfg_wdata = v;
    @(negedge clk); cfg_we = 0;
    case (i)
      4'd0: m_sr = v[3:0];
      4'd1: m_esr = v[3:0];
      4'd2: m_cc = v[3:0];
      4'd3: begin m_cnt = v[2:0]; m_fn = v[4:3]; end
      4'd4: m_rsel = v[1:0];
      4'd5: begin m_wm = v[1:0]; m_rm = v[3]; end
      4'd7: m_inc = v[3:0];
      4'd8: m_bm = v;
      default: ;
    endcase
  endtask

  task automatic set_mode(input logic [1:0] wm, input logic rm);
    cfg(4'd5, {4'h0, rm, 1'b0, wm});
  endtask

  function automatic logic [7:0] ror8(input logic [7:0] d, input logic [2:0] n);
    logic [15:0] t = {d, d} >> n;
    return t[7:0];
  endfunction

  function automatic logic [7:0] mdl_plane(input int p, input logic [7:0] d, input logic [7:0] l);
    logic [7:0] r = ror8(d, m_cnt);
    logic [7:0] s, a, k;
    if (m_wm == 2'd1) return l;
    if (m_wm == 2'd2) s = d[p] ? 8'hFF : 8'h00;
    else if (m_wm == 2'd3 || m_esr[p]) s = m_sr[p] ? 8'hFF : 8'h00;
    else s = r;
    case (m_fn)
      2'd0: a = s;
      2'd1: a = s & l;
      2'd2: a = s | l;
      default: a = s ^ l;
    endcase
    k = (m_wm == 2'd3) ? (r & m_bm) : m_bm;
    return (a & k) | (l & ~k);
  endfunction

  function automatic logic [7:0] mdl_read();
    logic [7:0] c;
    if (!m_rm) return mlat[m_rsel];
    for (int i = 0; i < 8; i++) begin
      c[i] = 1'b1;
      for (int p = 0; p < 4; p++)
        if (m_inc[p] && (mlat[p][i] != m_cc[p])) c[i] = 1'b0;
    end
    return c;
  endfunction

  task automatic hwr(input logic [3:0] a, input logic [7:0] d, input logic [3:0] pm);
    logic [7:0] nv [4];
    for (int p = 0; p < 4; p++) nv[p] = mdl_plane(p, d, mlat[p]);
    @(negedge clk); host_we = 1; host_addr = {4'h0, a}; host_wdata = d; plane_mask = pm;
    @(negedge clk); host_we = 0;
    for (int p = 0; p < 4; p++) if (pm[p]) mm[p][a] = nv[p];
  endtask

  task automatic hrd(input logic [3:0] a, input string tag);
    @(negedge clk); host_re = 1; host_addr = {4'h0, a};
    @(negedge clk); host_re = 0;
    for (int p = 0; p < 4; p++) mlat[p] = mm[p][a];
    chk("R8", {7'h0, host_rvalid}, 8'h01);
    chk(tag, host_rdata, mdl_read());
  endtask

  task automatic rd_plane(input logic [3:0] a, input int p, input string tag);
    cfg(4'd4, 8'(p));
    if (m_rm) set_mode(m_wm, 1'b0);
    hrd(a, tag);
  endtask

  initial begin
    for (int p = 0; p < 4; p++) mlat[p] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R8", {7'h0, host_rvalid}, 8'h00);
    chk("R8", host_rdata, 8'h00);

    for (int a = 0; a < 16; a++)
      for (int p = 0; p < 4; p++)
        hwr(4'(a), 8'(a * 37 + p * 91 + 5), 4'(1 << p));
    for (int a = 0; a < 16; a += 5)
      for (int p = 0; p < 4; p++) rd_plane(4'(a), p, "R9");

    hwr(4'd3, 8'h3C, 4'b0101);
    for (int p = 0; p < 4; p++) rd_plane(4'd3, p, "R11");

    cfg(4'd4, 8'h02);
    hrd(4'd5, "R1");
    cfg(4'd6, 8'hFF);
    hrd(4'd6, "R1");

    for (int wm = 0; wm < 4; wm++)
      for (int fn = 0; fn < 4; fn++)
        for (int k = 0; k < 4; k++) begin
          logic [3:0] a = 4'(fn * 4 + k);
          string tag;
          logic [7:0] bm = (k == 0) ? 8'hFF : 8'(8'hA5 ^ (k * 8'h1B));
          if (wm == 1) tag = "R3";
          else if (fn != 0) tag = "R6";
          else if (bm != 8'hFF) tag = "R7";
          else tag = (wm == 0) ? "R2" : (wm == 2) ? "R4" : "R5";
          cfg(4'd3, {3'h0, 2'(fn), 3'(k * 3 + wm)});
          cfg(4'd8, bm);
          cfg(4'd0, 8'(4'b1010 ^ k));
          cfg(4'd1, 8'((k * 5 + wm) & 15));
          set_mode(2'(wm), 1'b0);
          hrd(4'((a + 7) % 16), "R8");
          hwr(a, 8'(8'h5A + k * 29 + fn * 71 + wm * 13), 4'hF);
          for (int p = 0; p < 4; p++) rd_plane(a, p, tag);
        end

    set_mode(2'd1, 1'b0);
    hrd(4'd9, "R8");
    cfg(4'd3, 8'h1F);
    cfg(4'd8, 8'h00);
    hwr(4'd12, 8'hE7, 4'hF);
    for (int p = 0; p < 4; p++) rd_plane(4'd12, p, "R3");

    for (int k = 0; k < 8; k++) begin
      cfg(4'd2, 8'((k * 3) & 15));
      cfg(4'd7, (k == 0) ? 8'h00 : 8'((k * 7) & 15));
      set_mode(2'd0, 1'b1);
      for (int a = 0; a < 16; a += 3) hrd(4'(a), "R10");
    end

    finish_run();
  end
endmodule